// File: doc/BRIEF.md
# Multi-level indirect operand address resolver

This block turns the operand descriptor of a 32-bit instruction word into an effective memory address or an immediate operand value. The descriptor fields are an index register select, four mode flags and a signed 16-bit parameter. The parameter is sign-extended. The selected index register is added when the indexed flag is set, and the program counter is added when the relative flag is set. The calculation runs as a small multicycle state machine, started by a one-cycle `start` pulse.

When the indirect flag is set, the resolver reads a 32-bit word from memory at the address formed so far, through a request/valid port that tolerates any number of wait cycles. It then decodes that word again as a complete descriptor and repeats the calculation. The opcode byte of the fetched word is ignored. This continues for as long as each fetched word also carries the indirect flag, and it stops at a configurable depth limit. A finished calculation raises `done` for one cycle, with `result` and a flag that says whether the result is a value or an address. A calculation that reaches the depth limit raises `err` instead.

Top module: `indir_resolver`

## Requirements
- R1: With flag bit 19 set, the index register selected by bits 23..20 (read through `idx_sel`/`idx_data`) is added to the sign-extended parameter.
- R2: With flag bit 18 set, the program counter captured at `start` is added to the address being formed.
- R3: The parameter in bits 15..0 is sign-extended to 32 bits, and all additions wrap modulo 2^32.
- R4: With flag bit 17 set, one memory read is issued at the address formed so far. The calculation then restarts from bits 23..0 of the returned word, and bits 31..24 of that word have no effect.
- R5: `result_is_value` is bit 16 of the original instruction word. Bit 16 of fetched words has no effect.
- R6: When `is_jump` is high at `start`, `result_is_value` is 0 whatever bit 16 holds.
- R7: `mem_req` stays high and `mem_addr` stays stable until `mem_rvalid` is seen. Any number of wait cycles is accepted.
- R8: After MAX_DEPTH fetches, a word that still has bit 17 set ends the calculation with a one-cycle `err` and no `done`, and no further fetch is issued.
- R9: `done` rises two cycles after the edge that samples `start` when no indirection occurs. Each indirection adds two cycles plus the memory wait cycles.
- R10: After reset, `done`, `err`, `mem_req` and `busy` are low.
- R11: `start` is ignored while `busy` is high.
- R12: With flags P and N set and a parameter of 0, `result` equals the selected index register and `result_is_value` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (ignored while busy) |
| instr | input | 32 | Instruction word holding the operand descriptor |
| pc | input | 32 | Program counter, captured at start |
| is_jump | input | 1 | Instruction is a jump; immediate flag is ignored |
| idx_sel | output | 4 | Index register file read select |
| idx_data | input | 32 | Index register file read data |
| mem_req | output | 1 | Memory read request, held until valid |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle strobe: result is ready |
| result | output | 32 | Effective address or immediate value |
| result_is_value | output | 1 | Result is an operand value rather than an address |
| err | output | 1 | One-cycle strobe: indirection depth limit reached |

## Verification
`done` is due two cycles after the `start` edge for a direct operand. Every indirection adds two cycles plus the number of cycles for which the memory model withholds `mem_rvalid`. The bench counts falling edges from the `start` pulse until it sees `done` or `err`. It compares that count against 2 + (2 + waits) per fetch and samples every output on the falling edge. The memory model counts the fetches it serves, so the depth-limit case is checked by the exact number of reads as well as by the strobe.

// File: rtl/ir_pkg.sv
package ir_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CALC,
      ST_WAIT
   } ir_state_t;

   // operand descriptor as held in bits 23..0 of a word
   typedef struct packed {
      logic [3:0]  xsel;
      logic        f_idx;
      logic        f_rel;
      logic        f_ind;
      logic        f_imm;
      logic [15:0] prm;
   } ir_desc_t;

   localparam int DESC_W = 24;
   localparam int PRM_W  = 16;
endpackage

// File: rtl/ir_addr_calc.sv
module ir_addr_calc
   import ir_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  ir_desc_t            desc,
   input  logic [DATA_W-1:0]   idx_val,
   input  logic [DATA_W-1:0]   pc_val,
   output logic [DATA_W-1:0]   sum
);
   localparam int EXT_W = DATA_W - PRM_W;

   logic [DATA_W-1:0] ext_prm;
   logic [DATA_W-1:0] idx_term;
   logic [DATA_W-1:0] pc_term;

   assign ext_prm  = {{EXT_W{desc.prm[PRM_W-1]}}, desc.prm};
   assign idx_term = desc.f_idx ? idx_val : '0;
   assign pc_term  = desc.f_rel ? pc_val  : '0;
   assign sum      = ext_prm + idx_term + pc_term;
endmodule

// File: rtl/ir_depth_ctr.sv
module ir_depth_ctr #(
   parameter int MAX_DEPTH = 64,
   parameter bit LIMIT_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_limit
);
   localparam int CNT_W = $clog2(MAX_DEPTH + 1);

   if (MAX_DEPTH < 1) begin : g_bad_depth
      $error("ir_depth_ctr: MAX_DEPTH must be at least 1");
   end

   if (LIMIT_EN) begin : g_limited
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cnt <= '0;
         else if (clr) cnt <= '0;
         else if (inc) cnt <= cnt + 1'b1;
      end
      assign at_limit = (cnt == CNT_W'(MAX_DEPTH));

      p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CNT_W'(MAX_DEPTH));
   end else begin : g_unbounded
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, clr, inc};
      assign at_limit   = 1'b0;
   end
endmodule

// File: rtl/indir_resolver.sv
module indir_resolver
   import ir_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 4,
   parameter int MAX_DEPTH = 64,
   parameter bit LIMIT_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] instr,
   input  logic [DATA_W-1:0] pc,
   input  logic              is_jump,
   output logic [IDX_W-1:0]  idx_sel,
   input  logic [DATA_W-1:0] idx_data,
   output logic              mem_req,
   output logic [DATA_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              result_is_value,
   output logic              err
);
   if (DATA_W < DESC_W + 8) begin : g_bad_width
      $error("indir_resolver: DATA_W must hold opcode and descriptor");
   end
   if (IDX_W != 4) begin : g_bad_idx
      $error("indir_resolver: descriptor select field is 4 bits");
   end

   ir_state_t         state;
   ir_desc_t          desc_q;
   logic [DATA_W-1:0] pc_q;
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] res_q;
   logic              imm_q, isv_q, done_q, err_q;
   logic [DATA_W-1:0] sum;
   logic              at_limit;
   logic              accept, fetch_in;
   logic              unused_hi;

   assign unused_hi = ^{instr[DATA_W-1:DESC_W], mem_rdata[DATA_W-1:DESC_W]};
   assign accept    = start && (state == ST_IDLE);
   assign fetch_in  = (state == ST_WAIT) && mem_rvalid;

   ir_addr_calc #(.DATA_W(DATA_W)) u_calc (
      .desc    (desc_q),
      .idx_val (idx_data),
      .pc_val  (pc_q),
      .sum     (sum)
   );

   ir_depth_ctr #(.MAX_DEPTH(MAX_DEPTH), .LIMIT_EN(LIMIT_EN)) u_depth (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .inc      (fetch_in),
      .at_limit (at_limit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         desc_q <= '0;
         pc_q   <= '0;
         addr_q <= '0;
         res_q  <= '0;
         imm_q  <= 1'b0;
         isv_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               desc_q <= ir_desc_t'(instr[DESC_W-1:0]);
               pc_q   <= pc;
               imm_q  <= instr[16] && !is_jump;
               state  <= ST_CALC;
            end
            ST_CALC: begin
               if (desc_q.f_ind) begin
                  if (at_limit) begin
                     err_q <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     addr_q <= sum;
                     state  <= ST_WAIT;
                  end
               end else begin
                  res_q  <= sum;
                  isv_q  <= imm_q;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            ST_WAIT: if (mem_rvalid) begin
               desc_q <= ir_desc_t'(mem_rdata[DESC_W-1:0]);
               state  <= ST_CALC;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idx_sel         = desc_q.xsel;
   assign mem_req         = (state == ST_WAIT);
   assign mem_addr        = addr_q;
   assign busy            = (state != ST_IDLE);
   assign done            = done_q;
   assign err             = err_q;
   assign result          = res_q;
   assign result_is_value = isv_q;

   p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));
   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_rvalid |=> busy && !mem_req);
   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));
   p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy) && !busy);
endmodule

// File: tb/indir_resolver_test.sv
module indir_resolver_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] pc = '0;
   logic        is_jump = 1'b0;
   logic [3:0]  idx_sel;
   logic [31:0] idx_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        busy, done, err, result_is_value;
   logic [31:0] result;

   logic [31:0] xr  [16];
   logic [31:0] mem [64];
   int          wait_cfg = 0;
   int          fetches = 0;
   int          n_chk = 0;
   int          n_bad = 0;

   always #5 clk = ~clk;

   assign idx_data = xr[idx_sel];

   indir_resolver uut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
      .is_jump(is_jump), .idx_sel(idx_sel), .idx_data(idx_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .result(result),
      .result_is_value(result_is_value), .err(err)
   );

   // memory model: answers after wait_cfg idle cycles
   initial begin
      int wc;
      wc = 0;
      forever begin
         @(negedge clk);
         mem_rvalid = 1'b0;
         if (mem_req) begin
            if (wc >= wait_cfg) begin
               mem_rvalid = 1'b1;
               mem_rdata  = mem[mem_addr[5:0]];
               fetches++;
               wc = 0;
            end else wc++;
         end
      end
   end

   initial begin
      #2000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   function automatic logic [31:0] w(input logic [7:0] op, input logic [3:0] x,
                                     input logic [3:0] fl, input logic [15:0] p);
      return {op, x, fl, p};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   logic [31:0] r_res;
   logic        r_isv, r_err, r_done;
   int          r_cyc, r_fetch;

   task automatic run(input logic [31:0] ins, input logic jmp, input int wts,
                      input logic poke);
      wait_cfg = wts;
      fetches  = 0;
      @(negedge clk);
      instr = ins; is_jump = jmp; start = 1'b1;
      r_cyc = 0; r_done = 0; r_err = 0;
      @(negedge clk);
      start = 1'b0; instr = w(8'h00, 4'h0, 4'h0, 16'h003F);
      r_cyc = 1;
      for (int i = 0; i < 1000; i++) begin
         if (poke && r_cyc == 3) start = 1'b1;
         else start = 1'b0;
         @(negedge clk);
         r_cyc++;
         if (done || err) begin
            r_done = done; r_err = err; r_res = result; r_isv = result_is_value;
            break;
         end
      end
      start = 1'b0;
      r_fetch = fetches;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R10 done", {31'b0, done}, 32'd0);
      chk("R10 err", {31'b0, err}, 32'd0);
      chk("R10 mem_req", {31'b0, mem_req}, 32'd0);
      chk("R10 busy", {31'b0, busy}, 32'd0);
   endtask

   task automatic t_direct;
      run(w(8'h11, 4'h0, 4'b0000, 16'h0010), 1'b0, 0, 1'b0);
      chk("R9 direct latency", r_cyc, 2);
      chk("R9 direct result", r_res, 32'h10);
      chk("R9 direct is_value", {31'b0, r_isv}, 32'd0);
      run(w(8'h11, 4'h0, 4'b0000, 16'hFFF0), 1'b0, 0, 1'b0);
      chk("R3 sign extension", r_res, 32'hFFFF_FFF0);
   endtask

   task automatic t_relative;
      pc = 32'h0000_0020;
      run(w(8'h22, 4'h0, 4'b0100, 16'hFFF0), 1'b0, 0, 1'b0);
      chk("R2 pc relative wrap", r_res, 32'h10);
      pc = 32'h0000_1000;
      run(w(8'h22, 4'h0, 4'b0100, 16'h0004), 1'b0, 0, 1'b0);
      chk("R2 pc relative", r_res, 32'h1004);
      pc = '0;
   endtask

   task automatic t_indexed;
      run(w(8'h33, 4'h5, 4'b1000, 16'h0003), 1'b0, 0, 1'b0);
      chk("R1 indexed", r_res, 32'h1003);
      run(w(8'h33, 4'h9, 4'b1000, 16'h0002), 1'b0, 0, 1'b0);
      chk("R3 index wrap", r_res, 32'h1);
      run(w(8'h33, 4'h7, 4'b1001, 16'h0000), 1'b0, 0, 1'b0);
      chk("R12 read index reg", r_res, 32'hCAFE_0007);
      chk("R12 is_value", {31'b0, r_isv}, 32'd1);
   endtask

   task automatic t_jump;
      run(w(8'h44, 4'h0, 4'b0001, 16'h0021), 1'b1, 0, 1'b0);
      chk("R6 jump ignores imm", {31'b0, r_isv}, 32'd0);
      chk("R6 jump result", r_res, 32'h21);
      run(w(8'h44, 4'h0, 4'b0001, 16'h0021), 1'b0, 0, 1'b0);
      chk("R5 imm non-jump", {31'b0, r_isv}, 32'd1);
   endtask

   task automatic t_indirect;
      run(w(8'h55, 4'h0, 4'b0010, 16'h0004), 1'b0, 0, 1'b0);
      chk("R4 one level result", r_res, 32'h1001);
      chk("R4 one fetch", r_fetch, 1);
      chk("R9 one level latency", r_cyc, 4);
      run(w(8'h55, 4'h0, 4'b0010, 16'h0008), 1'b0, 3, 1'b0);
      chk("R7 two levels with waits", r_res, 32'h1020);
      chk("R7 latency with waits", r_cyc, 12);
      chk("R4 two fetches", r_fetch, 2);
   endtask

   task automatic t_imm_origin;
      run(w(8'h66, 4'h0, 4'b0011, 16'h0004), 1'b0, 0, 1'b0);
      chk("R5 imm from original", {31'b0, r_isv}, 32'd1);
      run(w(8'h66, 4'h0, 4'b0010, 16'h0010), 1'b0, 1, 1'b0);
      chk("R5 fetched imm ignored", {31'b0, r_isv}, 32'd0);
      chk("R5 fetched result", r_res, 32'h7);
   endtask

   task automatic t_depth;
      run(w(8'h77, 4'h0, 4'b0010, 16'h0000), 1'b0, 0, 1'b0);
      chk("R8 err raised", {31'b0, r_err}, 32'd1);
      chk("R8 no done", {31'b0, r_done}, 32'd0);
      chk("R8 fetch count", r_fetch, 64);
      chk("R8 no request after err", {31'b0, mem_req}, 32'd0);
   endtask

   task automatic t_busy_start;
      run(w(8'h88, 4'h0, 4'b0010, 16'h0004), 1'b0, 5, 1'b1);
      chk("R11 start while busy", r_res, 32'h1001);
      chk("R11 busy latency", r_cyc, 9);
      chk("R11 idle after", {31'b0, busy}, 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) xr[i] = 32'h0;
      xr[5] = 32'h0000_1000;
      xr[7] = 32'hCAFE_0007;
      xr[9] = 32'hFFFF_FFFF;
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      mem[0]  = w(8'hAA, 4'h0, 4'b0010, 16'h0000);
      mem[4]  = w(8'hFF, 4'h5, 4'b1000, 16'h0001);
      mem[8]  = w(8'h12, 4'h0, 4'b0010, 16'h000C);
      mem[12] = w(8'h34, 4'h5, 4'b1000, 16'h0020);
      mem[16] = w(8'h56, 4'h0, 4'b0001, 16'h0007);
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_direct;
      t_relative;
      t_indexed;
      t_jump;
      t_indirect;
      t_imm_origin;
      t_depth;
      t_busy_start;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule